// File: doc/BRIEF.md
# Paged Memory Window Controller

This block gives a host processor access to a large array of banked memory chips through one small window in its memory map. The memory behind the window is divided into 8 KB banks. Software picks a chip and a bank by writing two byte-wide registers in host I/O space. From then on, every host memory access that lands inside the 8 KB window is routed to that bank of that chip. The low thirteen address bits pass straight through as the offset inside the bank.

Two 2-bit board straps position the block. One strap picks which of four I/O addresses the registers answer at. The other picks which of four memory segments the window occupies. Each chip socket has a 3-bit memory-kind setting, fixed by a parameter. The seven-bit bank field that software writes is unscrambled according to that kind. Some kinds require fixed marker bits, and the wiring of the upper bank bits differs from one kind to the next. When the marker bits are wrong, the block leaves every chip idle and the host reads 0xFF. A write-protect flag in the bank register suppresses device write strobes across the whole window.

Top module: `paged_window_ctrl`

## Requirements
- R1: After synchronous reset, the bank register reads 0x00, the chip register reads 0x10, and no chip enable is asserted.
- R2: The registers answer at I/O address 0x2C0 + 0x10*io_strap. An I/O write to any other address leaves both registers unchanged. An I/O read of any other address returns 0x00 on io_rdata.
- R3: A write to base+0 stores all eight data bits. Bit 7 is the write-protect flag and bits 6..0 are the bank field. A read of base+0 returns the stored byte.
- R4: A write to base+1 stores data bits 2..0 as the chip number. A read of base+1 always returns 0001 in bits 7..4 and 0 in bit 3, with the chip number in bits 2..0.
- R5: The window starts at 0xC8000, 0xCC000, 0xD8000 or 0xDC000 for win_strap values 0 to 3. A host address hits the window only if its bits 19..13 equal those of the start address.
- R6: On a hit with a valid bank field, phys_addr is {bank[6:0], mem_addr[12:0]}. In every other case it is 0.
- R7: Kind 0 (64 KB flash) requires field bits 6..3 = 0010 and takes bank = field[2:0]. Kind 1 (128 KB flash) requires bits 6..4 = 001 and takes bank = field[3:0].
- R8: Kind 2 (256 KB flash) requires bit 6 = 0 and bit 4 = 1, and takes bank = {field[5], field[3:0]}. Kind 3 (512 KB flash) requires bit 6 = 0, and takes bank bit 5 from field bit 4, bank bit 4 from field bit 5, and bank bits 3..0 from field bits 3..0.
- R9: Kind 4 (1 MB EPROM) has no marker bits. Bank bit 6 comes from field bit 6, bank bit 5 from field bit 4, bank bit 4 from field bit 5, and bank bits 3..0 from field bits 3..0.
- R10: Kind 5 (128 KB SRAM) requires bits 6..4 = 010 and takes bank = field[3:0]. Kind 6 (512 KB SRAM) requires bit 6 = 0 and takes bank = field[5:0]. Kind 7 never matches.
- R11: A miss, or a hit whose marker bits do not match, asserts no chip enable, drives no write strobe, and returns 0xFF on mem_rdata.
- R12: While the write-protect flag is 1, dev_we stays low. Chip enables and read data are unaffected.
- R13: On a hit with a valid field and mem_rd or mem_wr high, exactly chip_en[chip number] is high. dev_we = mem_wr with write protect clear, and mem_rdata = dev_rdata on a read. The default kinds for chips 0..7 are 0,1,2,3,4,5,6,2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_strap | input | 2 | I/O base selection strap |
| win_strap | input | 2 | Window segment selection strap |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host I/O write strobe |
| io_rd | input | 1 | Host I/O read strobe |
| io_wdata | input | 8 | Host I/O write data |
| io_rdata | output | 8 | Host I/O read data |
| mem_addr | input | 20 | Host memory address |
| mem_rd | input | 1 | Host memory read strobe |
| mem_wr | input | 1 | Host memory write strobe |
| dev_rdata | input | 8 | Read data from the enabled chip |
| mem_rdata | output | 8 | Read data returned to the host |
| chip_en | output | 8 | One-hot chip enables |
| phys_addr | output | 20 | Bank and offset presented to the chips |
| dev_we | output | 1 | Write strobe to the enabled chip |

## Verification
The bench drives every memory kind with both a well-formed bank field and one whose marker bits are wrong. A design that swapped the two crossed bank bits of the 512 KB flash or the 1 MB EPROM kind would show a wrong phys_addr. A design that ignored the markers would enable a chip and return device data where 0xFF is due. The bench also probes the bytes just below and just above the window for every window strap, which catches an off-by-one segment compare. It writes to a stale I/O base after changing the strap, which catches a decoder that ignores the strap. Finally it writes with protect set, where a design that gated the chip enable rather than only the strobe would also lose reads.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    localparam int DATA_W  = 8;
    localparam int FIELD_W = 7;
    localparam int OFS_W   = 13;
    localparam int PA_W    = FIELD_W + OFS_W;
    localparam int SEG_W   = PA_W - OFS_W;
    localparam int KIND_W  = 3;

    typedef enum logic [KIND_W-1:0] {
        MK_FL64  = 3'd0,
        MK_FL128 = 3'd1,
        MK_FL256 = 3'd2,
        MK_FL512 = 3'd3,
        MK_EP1M  = 3'd4,
        MK_SR128 = 3'd5,
        MK_SR512 = 3'd6,
        MK_NONE  = 3'd7
    } mem_kind_e;

    typedef struct packed {
        logic               wp;
        logic [FIELD_W-1:0] field;
    } bank_reg_t;

    typedef struct packed {
        logic               ok;
        logic [FIELD_W-1:0] bank;
    } bank_map_t;

    // Undo the per-kind bit shuffle and check the fixed marker bits.
    function automatic bank_map_t unscramble(mem_kind_e k, logic [FIELD_W-1:0] a);
        bank_map_t m;
        m.ok   = 1'b0;
        m.bank = '0;
        case (k)
            MK_FL64: begin
                m.ok   = (a[6:3] == 4'b0010);
                m.bank = {4'b0, a[2:0]};
            end
            MK_FL128: begin
                m.ok   = (a[6:4] == 3'b001);
                m.bank = {3'b0, a[3:0]};
            end
            MK_FL256: begin
                m.ok   = !a[6] && a[4];
                m.bank = {2'b0, a[5], a[3:0]};
            end
            MK_FL512: begin
                m.ok   = !a[6];
                m.bank = {1'b0, a[4], a[5], a[3:0]};
            end
            MK_EP1M: begin
                m.ok   = 1'b1;
                m.bank = {a[6], a[4], a[5], a[3:0]};
            end
            MK_SR128: begin
                m.ok   = (a[6:4] == 3'b010);
                m.bank = {3'b0, a[3:0]};
            end
            MK_SR512: begin
                m.ok   = !a[6];
                m.bank = {1'b0, a[5:0]};
            end
            default: begin
                m.ok   = 1'b0;
                m.bank = '0;
            end
        endcase
        return m;
    endfunction

    function automatic logic [15:0] io_base(logic [1:0] s);
        return 16'h02C0 + {10'd0, s, 4'd0};
    endfunction

    // Window segment, as address bits 19..13 of its start.
    function automatic logic [SEG_W-1:0] win_seg(logic [1:0] s);
        logic [SEG_W-1:0] seg;
        case (s)
            2'd0:    seg = 7'h64;
            2'd1:    seg = 7'h66;
            2'd2:    seg = 7'h6C;
            default: seg = 7'h6E;
        endcase
        return seg;
    endfunction

endpackage

// File: rtl/pwc_regs.sv
module pwc_regs
    import pwc_pkg::*;
#(
    parameter int IO_AW = 16,
    parameter int CS_W  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          io_strap,
    input  logic [IO_AW-1:0]    io_addr,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [DATA_W-1:0]   io_wdata,
    output logic [DATA_W-1:0]   io_rdata,
    output bank_reg_t           bank_q,
    output logic [CS_W-1:0]     cs_q
);

    logic [IO_AW-1:0] base;
    logic             sel_bank;
    logic             sel_chip;
    logic [2:0]       cs_view;

    assign base     = IO_AW'(io_base(io_strap));
    assign sel_bank = (io_addr == base);
    assign sel_chip = (io_addr == base + IO_AW'(1));
    assign cs_view  = 3'(cs_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
            cs_q   <= '0;
        end else if (io_wr) begin
            if (sel_bank) bank_q <= bank_reg_t'(io_wdata);
            if (sel_chip) cs_q   <= io_wdata[CS_W-1:0];
        end
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd && sel_bank)      io_rdata = bank_q;
        else if (io_rd && sel_chip) io_rdata = {4'b0001, 1'b0, cs_view};
    end

endmodule

// File: rtl/pwc_bank_dec.sv
module pwc_bank_dec
    import pwc_pkg::*;
#(
    parameter int                          NUM_CHIPS  = 8,
    parameter int                          CS_W       = 3,
    parameter logic [NUM_CHIPS*KIND_W-1:0] CHIP_KINDS = '0
) (
    input  logic [CS_W-1:0]    cs,
    input  logic [FIELD_W-1:0] field,
    output bank_map_t          map
);

    mem_kind_e kind;

    assign kind = mem_kind_e'(CHIP_KINDS[cs*KIND_W +: KIND_W]);
    assign map  = unscramble(kind, field);

endmodule

// File: rtl/pwc_window.sv
module pwc_window
    import pwc_pkg::*;
#(
    parameter int NUM_CHIPS = 8,
    parameter int CS_W      = 3
) (
    input  logic [1:0]           win_strap,
    input  logic [PA_W-1:0]      mem_addr,
    input  logic                 mem_rd,
    input  logic                 mem_wr,
    input  logic [DATA_W-1:0]    dev_rdata,
    input  bank_map_t            map,
    input  logic [CS_W-1:0]      cs,
    input  logic                 wp,
    output logic [NUM_CHIPS-1:0] chip_en,
    output logic [PA_W-1:0]      phys_addr,
    output logic                 dev_we,
    output logic [DATA_W-1:0]    mem_rdata
);

    logic hit;
    logic valid;
    logic active;

    assign hit    = (mem_addr[PA_W-1:OFS_W] == win_seg(win_strap));
    assign valid  = hit && map.ok;
    assign active = valid && (mem_rd || mem_wr);

    for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_ce
        assign chip_en[i] = active && (cs == CS_W'(i));
    end

    assign phys_addr = valid ? {map.bank, mem_addr[OFS_W-1:0]} : '0;
    assign dev_we    = active && mem_wr && !wp;
    assign mem_rdata = (active && mem_rd) ? dev_rdata : {DATA_W{1'b1}};

endmodule

// File: rtl/paged_window_ctrl.sv
module paged_window_ctrl
    import pwc_pkg::*;
#(
    parameter int                          NUM_CHIPS  = 8,
    parameter int                          IO_AW      = 16,
    parameter logic [NUM_CHIPS*KIND_W-1:0] CHIP_KINDS =
        {3'd2, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           io_strap,
    input  logic [1:0]           win_strap,
    input  logic [IO_AW-1:0]     io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [DATA_W-1:0]    io_wdata,
    output logic [DATA_W-1:0]    io_rdata,
    input  logic [PA_W-1:0]      mem_addr,
    input  logic                 mem_rd,
    input  logic                 mem_wr,
    input  logic [DATA_W-1:0]    dev_rdata,
    output logic [DATA_W-1:0]    mem_rdata,
    output logic [NUM_CHIPS-1:0] chip_en,
    output logic [PA_W-1:0]      phys_addr,
    output logic                 dev_we
);

    localparam int CS_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;

    bank_reg_t       bank_q;
    logic [CS_W-1:0] cs_q;
    bank_map_t       map;

    pwc_regs #(
        .IO_AW (IO_AW),
        .CS_W  (CS_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .io_strap (io_strap),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .bank_q   (bank_q),
        .cs_q     (cs_q)
    );

    pwc_bank_dec #(
        .NUM_CHIPS  (NUM_CHIPS),
        .CS_W       (CS_W),
        .CHIP_KINDS (CHIP_KINDS)
    ) u_dec (
        .cs    (cs_q),
        .field (bank_q.field),
        .map   (map)
    );

    pwc_window #(
        .NUM_CHIPS (NUM_CHIPS),
        .CS_W      (CS_W)
    ) u_win (
        .win_strap (win_strap),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .dev_rdata (dev_rdata),
        .map       (map),
        .cs        (cs_q),
        .wp        (bank_q.wp),
        .chip_en   (chip_en),
        .phys_addr (phys_addr),
        .dev_we    (dev_we),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
    parameter int NUM_CHIPS = 8,
    parameter int IO_AW     = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           io_strap,
    input logic [IO_AW-1:0]     io_addr,
    input logic                 io_wr,
    input logic                 io_rd,
    input logic [7:0]           io_rdata,
    input logic [19:0]          mem_addr,
    input logic                 mem_rd,
    input logic [7:0]           mem_rdata,
    input logic [NUM_CHIPS-1:0] chip_en,
    input logic [19:0]          phys_addr,
    input logic                 dev_we,
    input logic [7:0]           bank_q
);

    logic [IO_AW-1:0] chk_base;
    assign chk_base = IO_AW'(16'h02C0) + IO_AW'({io_strap, 4'h0});

    AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chip_en));                                              // R13

    AST_WP_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        bank_q[7] |-> !dev_we);                                          // R12

    AST_IDLE_READS_FF: assert property (@(posedge clk) disable iff (rst)
        (chip_en == '0) |-> (mem_rdata == 8'hFF && !dev_we));             // R11

    AST_CHIP_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == chk_base + IO_AW'(1)) |-> (io_rdata[7:3] == 5'b00010)); // R4

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_addr == chk_base) |=> $stable(bank_q));            // R2

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        (chip_en != '0) |-> (phys_addr[12:0] == mem_addr[12:0]));        // R6

endmodule

bind paged_window_ctrl pwc_checker #(
    .NUM_CHIPS (NUM_CHIPS),
    .IO_AW     (IO_AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_strap  (io_strap),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_rdata  (io_rdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .chip_en   (chip_en),
    .phys_addr (phys_addr),
    .dev_we    (dev_we),
    .bank_q    (bank_q)
);

// File: tb/tb_paged_window_ctrl.sv
`timescale 1ns/1ps
module tb_paged_window_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  io_strap, win_strap;
    logic [15:0] io_addr;
    logic        io_wr, io_rd;
    logic [7:0]  io_wdata, io_rdata;
    logic [19:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  dev_rdata;
    logic [7:0]  mem_rdata;
    logic [7:0]  chip_en;
    logic [19:0] phys_addr;
    logic        dev_we;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    paged_window_ctrl dut (
        .clk(clk), .rst(rst), .io_strap(io_strap), .win_strap(win_strap),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .dev_rdata(dev_rdata), .mem_rdata(mem_rdata), .chip_en(chip_en),
        .phys_addr(phys_addr), .dev_we(dev_we)
    );

    typedef struct {
        string       tag;
        bit          is_io;
        logic [7:0]  io;
        logic [7:0]  ce;
        logic [19:0] pa;
        logic        we;
        logic [7:0]  md;
    } exp_t;

    exp_t exp_q[$];
    event go;

    // Bench-side model of the programmed state.
    logic [6:0] m_field;
    logic       m_wp;
    logic [2:0] m_cs;
    int         m_kind [8] = '{0, 1, 2, 3, 4, 5, 6, 2};

    function automatic logic [15:0] base_of(logic [1:0] s);
        return 16'h02C0 + 16'(s) * 16'h10;
    endfunction

    function automatic logic [19:0] win_start(logic [1:0] s);
        logic [19:0] t [4] = '{20'hC8000, 20'hCC000, 20'hD8000, 20'hDC000};
        return t[s];
    endfunction

    // Returns {ok, bank} from the kind descriptions in the requirements.
    function automatic logic [7:0] model_bank(int k, logic [6:0] f);
        logic ok;
        logic [6:0] b;
        ok = 1'b0; b = '0;
        if (k == 0)      begin ok = f[6:3] == 4'b0010; b[2:0] = f[2:0]; end
        else if (k == 1) begin ok = f[6:4] == 3'b001;  b[3:0] = f[3:0]; end
        else if (k == 2) begin ok = !f[6] && f[4]; b[3:0] = f[3:0]; b[4] = f[5]; end
        else if (k == 3) begin ok = !f[6]; b[3:0] = f[3:0]; b[4] = f[5]; b[5] = f[4]; end
        else if (k == 4) begin ok = 1'b1;  b[3:0] = f[3:0]; b[4] = f[5]; b[5] = f[4]; b[6] = f[6]; end
        else if (k == 5) begin ok = f[6:4] == 3'b010;  b[3:0] = f[3:0]; end
        else if (k == 6) begin ok = !f[6]; b[5:0] = f[5:0]; end
        return {ok, b};
    endfunction

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_check(input logic [15:0] a, input logic [7:0] expv, input string tag);
        exp_t e;
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        e.tag = tag; e.is_io = 1'b1; e.io = expv;
        exp_q.push_back(e);
        -> go;
        #1;
        io_rd = 1'b0;
    endtask

    task automatic mem_access(input logic [19:0] a, input logic rd, input logic wr, input string tag);
        exp_t e;
        logic [7:0] mb;
        logic hit, act;
        mb  = model_bank(m_kind[m_cs], m_field);
        hit = (a[19:13] == win_start(win_strap)[19:13]);
        act = hit && mb[7] && (rd || wr);
        e.tag   = tag;
        e.is_io = 1'b0;
        e.io    = '0;
        e.ce    = act ? (8'd1 << m_cs) : 8'd0;
        e.pa    = (hit && mb[7]) ? {mb[6:0], a[12:0]} : 20'd0;
        e.we    = act && wr && !m_wp;
        e.md    = (act && rd) ? dev_rdata : 8'hFF;
        @(negedge clk);
        mem_addr = a; mem_rd = rd; mem_wr = wr;
        #1;
        exp_q.push_back(e);
        -> go;
        #1;
        mem_rd = 1'b0; mem_wr = 1'b0;
    endtask

    task automatic set_bank(input logic wp, input logic [6:0] f);
        io_write(base_of(io_strap), {wp, f});
        m_wp = wp; m_field = f;
    endtask

    task automatic set_chip(input logic [2:0] c);
        io_write(base_of(io_strap) + 16'd1, {5'b0, c});
        m_cs = c;
    endtask

    // Monitor: pops expected items and compares with the outputs.
    initial begin
        forever begin
            @(go);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (e.is_io) begin
                    if (io_rdata !== e.io) begin
                        bad++;
                        $display("FAIL %s io_rdata act=%h exp=%h", e.tag, io_rdata, e.io);
                    end
                end else if (chip_en !== e.ce || phys_addr !== e.pa ||
                             dev_we !== e.we || mem_rdata !== e.md) begin
                    bad++;
                    $display("FAIL %s act ce=%h pa=%h we=%b rd=%h exp ce=%h pa=%h we=%b rd=%h",
                             e.tag, chip_en, phys_addr, dev_we, mem_rdata,
                             e.ce, e.pa, e.we, e.md);
                end
            end
        end
    end

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; io_strap = 2'd0; win_strap = 2'd0;
        io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
        mem_addr = '0; mem_rd = 1'b0; mem_wr = 1'b0; dev_rdata = 8'h5A;
        m_field = '0; m_wp = 1'b0; m_cs = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset contents
        io_check(16'h02C0, 8'h00, "R1 bank reset");
        io_check(16'h02C1, 8'h10, "R1 chip reset");
        mem_access(20'hC8010, 1'b1, 1'b0, "R1 no enable after reset");

        // R3: full byte readback
        set_bank(1'b0, 7'h7F);
        io_check(16'h02C0, 8'h7F, "R3 readback 7F");
        set_bank(1'b1, 7'h05);
        io_check(16'h02C0, 8'h85, "R3 readback 85");

        // R4: chip register view, bit 3 never set
        io_write(16'h02C1, 8'hFF);
        m_cs = 3'd7;
        io_check(16'h02C1, 8'h17, "R4 chip FF written");

        // R2: moved base; old address ignored
        io_strap = 2'd2;
        io_write(16'h02C0, 8'h33);
        io_check(16'h02E0, 8'h85, "R2 stale base write ignored");
        io_check(16'h02C0, 8'h00, "R2 stale base read zero");
        io_check(16'h02E1, 8'h17, "R2 chip at new base");
        io_strap = 2'd1;
        io_check(16'h02D0, 8'h85, "R2 base strap 1");
        io_strap = 2'd0;

        // R7..R10, R13: per-kind unscramble with valid fields
        set_chip(3'd0); set_bank(1'b0, 7'h15);
        mem_access(20'hC9ABC, 1'b1, 1'b0, "R7 fl64 read");
        mem_access(20'hC8001, 1'b0, 1'b1, "R13 fl64 write");
        set_chip(3'd1); set_bank(1'b0, 7'h1B);
        mem_access(20'hC8123, 1'b1, 1'b0, "R7 fl128");
        set_chip(3'd2); set_bank(1'b0, 7'h36);
        mem_access(20'hC9FFF, 1'b1, 1'b0, "R8 fl256");
        set_chip(3'd3); set_bank(1'b0, 7'h29);
        mem_access(20'hC8000, 1'b1, 1'b0, "R8 fl512 a5 set");
        set_bank(1'b0, 7'h19);
        mem_access(20'hC8444, 1'b0, 1'b1, "R8 fl512 a4 set");
        set_chip(3'd4); set_bank(1'b0, 7'h55);
        mem_access(20'hC8777, 1'b1, 1'b0, "R9 eprom 55");
        set_bank(1'b0, 7'h6A);
        mem_access(20'hC8778, 1'b1, 1'b0, "R9 eprom 6A");
        set_chip(3'd5); set_bank(1'b0, 7'h2C);
        mem_access(20'hC8002, 1'b1, 1'b0, "R10 sram128");
        set_chip(3'd6); set_bank(1'b0, 7'h3F);
        mem_access(20'hC9F00, 1'b0, 1'b1, "R10 sram512");
        set_chip(3'd7); set_bank(1'b0, 7'h11);
        mem_access(20'hC8040, 1'b1, 1'b0, "R13 chip7 fl256");

        // R11: marker mismatches
        set_chip(3'd0); set_bank(1'b0, 7'h05);
        mem_access(20'hC8100, 1'b1, 1'b0, "R11 fl64 bad marker");
        set_chip(3'd2); set_bank(1'b0, 7'h26);
        mem_access(20'hC8100, 1'b0, 1'b1, "R11 fl256 bad marker");
        set_chip(3'd6); set_bank(1'b0, 7'h40);
        mem_access(20'hC8100, 1'b1, 1'b0, "R11 sram512 bad marker");
        set_chip(3'd5); set_bank(1'b0, 7'h1C);
        mem_access(20'hC8100, 1'b1, 1'b0, "R11 sram128 bad marker");

        // R5, R6: window placement and edges
        set_chip(3'd6); set_bank(1'b0, 7'h2A);
        for (int s = 0; s < 4; s++) begin
            win_strap = 2'(s);
            mem_access(win_start(2'(s)), 1'b1, 1'b0, "R5 window start");
            mem_access(win_start(2'(s)) + 20'h1FFF, 1'b1, 1'b0, "R6 window last byte");
            mem_access(win_start(2'(s)) - 20'h1, 1'b1, 1'b0, "R5 below window");
            mem_access(win_start(2'(s)) + 20'h2000, 1'b1, 1'b0, "R5 above window");
        end
        win_strap = 2'd0;
        mem_access(20'hC8055, 1'b0, 1'b0, "R13 idle no enable");

        // R12: write protect
        set_bank(1'b1, 7'h2A);
        mem_access(20'hC8200, 1'b0, 1'b1, "R12 protected write");
        mem_access(20'hC8200, 1'b1, 1'b0, "R12 protected read");
        set_bank(1'b0, 7'h2A);
        mem_access(20'hC8200, 1'b0, 1'b1, "R12 unprotected write");

        // R1: reset again clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_field = '0; m_wp = 1'b0; m_cs = '0;
        io_check(16'h02C1, 8'h10, "R1 chip after second reset");

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule